// File: doc/BRIEF.md
# Iterative 256-bit Hash Compression Core

This block holds the eight 32-bit chaining words of a 256-bit hash and runs its 64-round compression function at one round per clock. A message expander outside the block delivers, for each round, a word pair made of the expanded word W and the mixed word W' (W xor the word four places later). The pair arrives on a valid/ready stream. When the last round has been accepted, the block xors the working state into the stored chaining value. It then raises a one-cycle completion pulse and presents the new 256-bit value on the digest output.

Before the first block of a message the control logic pulses the initialise input, which loads the standard initial value. Each block then starts with a start pulse. The chaining value stays in place between blocks, so a message of several blocks is hashed by repeating start and feeding 64 more word pairs. Padding and message framing are done upstream.

Back-pressure: the core raises `wpair_ready` only while a block is in progress. A word pair is consumed on each rising clock edge where both `wpair_valid` and `wpair_ready` are high. While `wpair_valid` is low the working state and the round index hold. The producer may stall for any number of cycles between pairs.

Top module: `hash256_round_core`

## Requirements
- R1: After reset, `digest` is all zeros, `done` is low and `wpair_ready` is low.
- R2: A pulse on `init_iv` while idle sets `digest`, from the next cycle, to 7380166f 4914b2b9 172442d7 da8a0600 a96f30bc 163138aa e38dee4d b0fb0e4e. Word A sits in bits 255:224 and word H in bits 31:0.
- R3: A `start` pulse while idle raises `wpair_ready` in the next cycle. The core accepts exactly 64 word pairs and then drops `wpair_ready`.
- R4: A cycle with `wpair_valid` low consumes no pair and advances no round, so stalls anywhere in a block leave the final digest unchanged.
- R5: Rounds 0 to 15 use the three-way xor for both boolean functions and constant rol(79cc4519, j). Rounds 16 to 63 use majority and select, with constant rol(7a879d8a, j mod 32).
- R6: For the single padded block of the three-byte message "abc", the digest is 66c7f0f4 62eeedd9 d1f2d46b dc10e4e2 4167c487 5cf2f7a2 297da02b 8f4ba8e0.
- R7: `done` is high for exactly one cycle per block, two cycles after the final pair is consumed. `digest` shows the new value in that same cycle.
- R8: The chaining value after a block, which is the old value xor the working words, is the input state of the next block.
- R9: `init_iv` and `start` have no effect while a block is in progress. The digest output holds and the block finishes with the same result.
- R10: Between `init_iv` and the end of a block, `digest` changes only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin compressing one block (used while idle) |
| init_iv | input | 1 | Load the standard initial value (used while idle) |
| wpair_valid | input | 1 | Word pair on w_word / wx_word is valid |
| wpair_ready | output | 1 | Core will take a word pair this cycle |
| w_word | input | 32 | Expanded message word W for the current round |
| wx_word | input | 32 | Mixed word W' for the current round |
| done | output | 1 | One-cycle pulse: digest holds the new chaining value |
| digest | output | 256 | Chaining value, word A in the top bits |

## Verification
The bench builds the core with its default parameters: 64 rounds and the function switch at round 16. With these values the known-answer block and a chained second block exercise both halves of the round schedule, including the constant rotation wrapping at round 32. A stalled feed covers the hold path of R4. Control pulses inside a running block cover the ignore rules of R9.

// File: rtl/hash256_pkg.sv
package hash256_pkg;

  typedef logic [31:0] word_t;

  // Word a occupies the most significant position of the packed struct.
  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } hstate_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FOLD = 2'd2
  } core_st_e;

  localparam word_t T_EARLY = 32'h79cc4519;
  localparam word_t T_LATE  = 32'h7a879d8a;

  localparam hstate_t INIT_VALUE = '{
    a: 32'h7380166f, b: 32'h4914b2b9, c: 32'h172442d7, d: 32'hda8a0600,
    e: 32'ha96f30bc, f: 32'h163138aa, g: 32'he38dee4d, h: 32'hb0fb0e4e
  };

  function automatic word_t rotl(input word_t x, input int unsigned n);
    int unsigned k;
    k = n % 32;
    if (k == 0) return x;
    return (x << k) | (x >> (32 - k));
  endfunction

  function automatic word_t perm0(input word_t x);
    return x ^ rotl(x, 9) ^ rotl(x, 17);
  endfunction

endpackage

// File: rtl/hash256_const_gen.sv
module hash256_const_gen
  import hash256_pkg::*;
#(
  parameter int ROUNDS       = 64,
  parameter int SWITCH_ROUND = 16,
  localparam int IW          = $clog2(ROUNDS)
) (
  input  logic [IW-1:0] rnd_idx,
  output word_t         rnd_const,
  output logic          late_phase
);

  word_t base_w;

  always_comb begin
    late_phase = (int'(rnd_idx) >= SWITCH_ROUND);
    base_w     = late_phase ? T_LATE : T_EARLY;
    rnd_const  = rotl(base_w, int'(rnd_idx) % 32);
  end

endmodule

// File: rtl/hash256_round.sv
module hash256_round
  import hash256_pkg::*;
(
  input  hstate_t cur,
  input  word_t   k_j,
  input  logic    late_phase,
  input  word_t   w_j,
  input  word_t   wx_j,
  output hstate_t nxt
);

  word_t a_rot, mix1, mix2, f_ab, g_ef, sum1, sum2;

  always_comb begin
    a_rot = rotl(cur.a, 12);
    mix1  = rotl(a_rot + cur.e + k_j, 7);
    mix2  = mix1 ^ a_rot;

    if (late_phase) begin
      f_ab = (cur.a & cur.b) | (cur.a & cur.c) | (cur.b & cur.c);
      g_ef = (cur.e & cur.f) | (~cur.e & cur.g);
    end else begin
      f_ab = cur.a ^ cur.b ^ cur.c;
      g_ef = cur.e ^ cur.f ^ cur.g;
    end

    sum1 = f_ab + cur.d + mix2 + wx_j;
    sum2 = g_ef + cur.h + mix1 + w_j;

    nxt.a = sum1;
    nxt.b = cur.a;
    nxt.c = rotl(cur.b, 9);
    nxt.d = cur.c;
    nxt.e = perm0(sum2);
    nxt.f = cur.e;
    nxt.g = rotl(cur.f, 19);
    nxt.h = cur.g;
  end

endmodule

// File: rtl/hash256_ctrl.sv
module hash256_ctrl
  import hash256_pkg::*;
#(
  parameter int ROUNDS = 64,
  localparam int IW    = $clog2(ROUNDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          init_iv,
  input  logic          pair_valid,
  output logic          pair_ready,
  output logic          take_iv,
  output logic          take_start,
  output logic          fire,
  output logic          fold,
  output logic          done_q,
  output logic [IW-1:0] rnd_idx
);

  localparam logic [IW-1:0] LAST = IW'(ROUNDS - 1);

  core_st_e st;

  always_comb begin
    take_iv    = (st == ST_IDLE) && init_iv;
    take_start = (st == ST_IDLE) && start && !init_iv;
    pair_ready = (st == ST_RUN);
    fire       = pair_ready && pair_valid;
    fold       = (st == ST_FOLD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rnd_idx <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fold;
      case (st)
        ST_IDLE: if (take_start) begin
          st      <= ST_RUN;
          rnd_idx <= '0;
        end
        ST_RUN: if (fire) begin
          if (rnd_idx == LAST) st <= ST_FOLD;
          rnd_idx <= rnd_idx + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hash256_round_core.sv
module hash256_round_core
  import hash256_pkg::*;
#(
  parameter int ROUNDS       = 64,
  parameter int SWITCH_ROUND = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         init_iv,
  input  logic         wpair_valid,
  output logic         wpair_ready,
  input  logic [31:0]  w_word,
  input  logic [31:0]  wx_word,
  output logic         done,
  output logic [255:0] digest
);

  localparam int IW = $clog2(ROUNDS);

  logic          take_iv, take_start, fire, fold;
  logic [IW-1:0] rnd_idx;
  word_t         k_j;
  logic          late_phase;
  hstate_t       chain_q, work_q, work_nxt;

  hash256_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .init_iv    (init_iv),
    .pair_valid (wpair_valid),
    .pair_ready (wpair_ready),
    .take_iv    (take_iv),
    .take_start (take_start),
    .fire       (fire),
    .fold       (fold),
    .done_q     (done),
    .rnd_idx    (rnd_idx)
  );

  hash256_const_gen #(.ROUNDS(ROUNDS), .SWITCH_ROUND(SWITCH_ROUND)) u_kgen (
    .rnd_idx    (rnd_idx),
    .rnd_const  (k_j),
    .late_phase (late_phase)
  );

  hash256_round u_round (
    .cur        (work_q),
    .k_j        (k_j),
    .late_phase (late_phase),
    .w_j        (w_word),
    .wx_j       (wx_word),
    .nxt        (work_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      work_q  <= '0;
    end else begin
      if (take_iv)       chain_q <= INIT_VALUE;
      else if (fold)     chain_q <= chain_q ^ work_q;
      if (take_start)    work_q  <= chain_q;
      else if (fire)     work_q  <= work_nxt;
    end
  end

  assign digest = chain_q;

endmodule

// File: rtl/hash256_round_core_chk.sv
module hash256_round_core_chk #(
  parameter int ROUNDS = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         init_iv,
  input logic         wpair_valid,
  input logic         wpair_ready,
  input logic         done,
  input logic [255:0] digest
);

  localparam int CW = $clog2(ROUNDS) + 1;

  logic [CW-1:0] hs_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                         hs_cnt <= '0;
    else if (done)                      hs_cnt <= '0;
    else if (wpair_valid && wpair_ready) hs_cnt <= hs_cnt + 1'b1;
  end

  // R7: completion lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: exactly the full round count is consumed before completion
  p_round_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hs_cnt == CW'(ROUNDS)));

  // R3: the stream opens only after a start request
  p_open_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wpair_ready) |-> $past(start));

  // R4: a stall never closes the stream mid-block
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wpair_ready && !wpair_valid) |=> wpair_ready);

  // R10: the chaining value moves only on completion or initialisation
  p_digest_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (digest != $past(digest)) |-> (done || $past(init_iv)));

  // R3: no pair is requested in the completion cycle
  p_no_ready_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wpair_ready);

endmodule

bind hash256_round_core hash256_round_core_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .init_iv     (init_iv),
  .wpair_valid (wpair_valid),
  .wpair_ready (wpair_ready),
  .done        (done),
  .digest      (digest)
);

// File: tb/test_hash256_round_core.sv
`timescale 1ns/1ps
module test_hash256_round_core;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         init_iv = 1'b0;
  logic         wpair_valid = 1'b0;
  logic         wpair_ready;
  logic [31:0]  w_word = '0;
  logic [31:0]  wx_word = '0;
  logic         done;
  logic [255:0] digest;

  int checks = 0;
  int errors = 0;

  localparam logic [255:0] IV_EXP  = 256'h7380166f4914b2b9172442d7da8a0600a96f30bc163138aae38dee4db0fb0e4e;
  localparam logic [255:0] ABC_EXP = 256'h66c7f0f462eeedd9d1f2d46bdc10e4e24167c4875cf2f7a2297da02b8f4ba8e0;

  always #2 clk = ~clk;  // 250 MHz

  hash256_round_core i_hash256_round_core (
    .clk(clk), .rst_n(rst_n), .start(start), .init_iv(init_iv),
    .wpair_valid(wpair_valid), .wpair_ready(wpair_ready),
    .w_word(w_word), .wx_word(wx_word), .done(done), .digest(digest)
  );

  logic [31:0]  blk  [16];
  logic [31:0]  wexp [68];
  logic [255:0] model_cv;
  logic [255:0] sb_q [$];
  string        tag_q [$];

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int k = n % 32;
    return (k == 0) ? x : ((x << k) | (x >> (32 - k)));
  endfunction

  task automatic expand();
    for (int i = 0; i < 16; i++) wexp[i] = blk[i];
    for (int i = 16; i < 68; i++) begin
      logic [31:0] t;
      t = wexp[i-16] ^ wexp[i-9] ^ rl(wexp[i-3], 15);
      wexp[i] = (t ^ rl(t, 15) ^ rl(t, 23)) ^ rl(wexp[i-13], 7) ^ wexp[i-6];
    end
  endtask

  // Reference compression built from R5 and R8.
  function automatic logic [255:0] ref_compress(input logic [255:0] cv);
    logic [31:0] a, b, c, d, e, f, g, h, s1, s2, t1, t2, fx, gx, k;
    {a, b, c, d, e, f, g, h} = cv;
    for (int j = 0; j < 64; j++) begin
      k  = rl((j < 16) ? 32'h79cc4519 : 32'h7a879d8a, j);
      s1 = rl(rl(a, 12) + e + k, 7);
      s2 = s1 ^ rl(a, 12);
      fx = (j < 16) ? (a ^ b ^ c) : ((a & b) | (a & c) | (b & c));
      gx = (j < 16) ? (e ^ f ^ g) : ((e & f) | (~e & g));
      t1 = fx + d + s2 + (wexp[j] ^ wexp[j+4]);
      t2 = gx + h + s1 + wexp[j];
      d = c; c = rl(b, 9); b = a; a = t1;
      h = g; g = rl(f, 19); f = e; e = t2 ^ rl(t2, 9) ^ rl(t2, 17);
    end
    return cv ^ {a, b, c, d, e, f, g, h};
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_init();
    @(negedge clk); init_iv = 1'b1;
    @(negedge clk); init_iv = 1'b0;
    model_cv = IV_EXP;
  endtask

  // Driver: pushes the expected digest, then streams 64 word pairs.
  // gaps: stall before some pairs. disturb: pulse init_iv and start mid-block.
  task automatic run_block(input logic [255:0] expect_v, input string req, input bit gaps, input bit disturb);
    int  j = 0;
    bit  stalled = 0;
    sb_q.push_back(expect_v);
    tag_q.push_back(req);
    model_cv = expect_v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (j < 64) begin
      if (j != 0 || stalled) @(negedge clk);
      if (disturb && j == 20) begin
        init_iv = 1'b1; start = 1'b1;
      end else begin
        init_iv = 1'b0; start = 1'b0;
      end
      if (disturb && j == 21)
        check(digest == tag_cv, "R9 digest held during block", digest, tag_cv);
      if (gaps && (j % 5 == 2) && !stalled) begin
        wpair_valid = 1'b0;
        stalled = 1;
      end else begin
        wpair_valid = 1'b1;
        w_word  = wexp[j];
        wx_word = wexp[j] ^ wexp[j+4];
        if (wpair_ready) begin
          j++;
          stalled = 0;
        end
      end
    end
    @(negedge clk);
    wpair_valid = 1'b0;
    init_iv = 1'b0; start = 1'b0;
    check(wpair_ready == 1'b0, "R3 ready drops after 64 pairs", 256'(wpair_ready), 256'(0));
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  logic [255:0] tag_cv;

  // Monitor: compares each completion against the scoreboard.
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(done == 1'b0, "R7 done single cycle", 256'(done), 256'(0));
      if (done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected done", 256'(1), 256'(0));
        end else begin
          logic [255:0] e;
          string t;
          e = sb_q.pop_front();
          t = tag_q.pop_front();
          check(digest == e, t, digest, e);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] exp2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(digest == '0, "R1 digest after reset", digest, '0);
    check(done == 1'b0, "R1 done after reset", 256'(done), 256'(0));
    check(wpair_ready == 1'b0, "R1 ready after reset", 256'(wpair_ready), 256'(0));

    // R2
    pulse_init();
    check(digest == IV_EXP, "R2 initial value loaded", digest, IV_EXP);
    check(digest[255:224] == 32'h7380166f, "R2 word A in top bits", 256'(digest[255:224]), 256'h7380166f);

    // "abc" padded block
    for (int i = 0; i < 16; i++) blk[i] = 32'h0;
    blk[0]  = 32'h61626380;
    blk[15] = 32'h00000018;
    expand();
    check(ref_compress(IV_EXP) == ABC_EXP, "R5 schedule gives known answer", ref_compress(IV_EXP), ABC_EXP);

    // R6: known answer, continuous feed
    run_block(ABC_EXP, "R6 abc digest", 1'b0, 1'b0);

    // R8 + R4: second block chained, stalled feed
    for (int i = 0; i < 16; i++) blk[i] = (32'h9e3779b9 * (i + 7)) ^ (32'(i) << 20);
    expand();
    exp2 = ref_compress(model_cv);
    run_block(exp2, "R8 chained block with stalls R4", 1'b1, 1'b0);

    // R9: control pulses inside a running block are ignored
    for (int i = 0; i < 16; i++) blk[i] = 32'h0f1e2d3c + 32'(i * 32'h01010101);
    expand();
    tag_cv = model_cv;
    exp2 = ref_compress(model_cv);
    run_block(exp2, "R9 result with ignored controls", 1'b0, 1'b1);

    // R2 again, then R6 with stalls R4
    pulse_init();
    check(digest == IV_EXP, "R2 re-initialise", digest, IV_EXP);
    for (int i = 0; i < 16; i++) blk[i] = 32'h0;
    blk[0]  = 32'h61626380;
    blk[15] = 32'h00000018;
    expand();
    run_block(ABC_EXP, "R6 abc digest with stalls R4", 1'b1, 1'b0);
    check(digest == ABC_EXP, "R10 digest holds after block", digest, ABC_EXP);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule